// File: doc/BRIEF.md
# Reset-Strapped Shared Pin Controller

This block decides what a small group of shared pins carry. Two strap levels are captured as reset is released. Software control bits then refine the result. While reset is asserted, the master-clock pin is an input that reads a strap level, and every chip select stays inactive. The four upper-address pins carry bus address bits 12 to 15 into the chip unless the clock-pin strap was low. In that case the disk-drive interface is enabled and those pins become outputs, with an active-low primary chip select on the lowest of them.

A second strap input decides whether a three-way shared pin acts as a general-purpose output or as an alternate chip select. A software volume-control enable overrides both of those roles and turns the pin into a button input. After reset the master-clock pin drives the clock, and a clock-disable bit can stop it. Both chip selects compare the bus address with a programmable base register through a parameterised compare mask.

The controller is a three-state machine. ST_HOLD is the reset state. ST_RUN is normal operation with the clock running. ST_STOP is normal operation with the clock held low. The transitions are: any state to ST_HOLD while `rst` is high; ST_HOLD to ST_RUN at the first clock edge with `rst` low, which is the edge that latches the straps; ST_RUN to ST_STOP when `clk_dis` is seen high at an edge; ST_STOP to ST_RUN when `clk_dis` is seen low at an edge.

Top module: `pinmux_strap_top`

## Requirements
- R1: While reset is held, the design drives the following. `mclk_oe`=0. `hi_pin_oe`=0 and `hi_pin_o`=4'hF. The shared pin drives high with `xpin_oe`=1 and `xpin_o`=1. `vol_btn`=0.
- R2: The straps `mclk_pin_i` and `alt_strap_i` are captured at the first rising edge that sees `rst` low. Later changes to them have no effect until the next reset.
- R3: A captured `mclk_pin_i` of 1 leaves the upper pins as inputs: `hi_pin_oe`=0 and `addr_hi`=`hi_pin_i`. A captured 0 makes them outputs: `hi_pin_oe`=4'hF and `addr_hi`=0.
- R4: With the disk interface enabled, `hi_pin_o[0]` is the primary chip select. It is 0 when `bus_addr` matches `cd_base` under the mask and 1 otherwise. `hi_pin_o[3:1]` are driven to 1. The select follows `bus_addr` in the same cycle.
- R5: With a captured `alt_strap_i` of 1 and `vol_en`=0, the shared pin is an output (`xpin_oe`=1) and `xpin_o` equals `gpo_bit`.
- R6: With a captured `alt_strap_i` of 0 and `vol_en`=0, `xpin_o` is the alternate chip select. It is 0 on a masked match with `alt_base` and 1 otherwise. `gpo_bit` has no effect on it.
- R7: Outside reset, `vol_en`=1 makes `xpin_oe`=0 and `vol_btn`=`xpin_i`, whatever the straps are. With `vol_en`=0, `vol_btn`=0.
- R8: After reset, `mclk_oe`=1 and `mclk_out` follows `mclk_src` while the clock is running.
- R9: When `clk_dis` is set, `mclk_out` goes to 0 from the next rising edge onward. When `clk_dis` is cleared, it follows `mclk_src` again from the next rising edge.
- R10: Address bits where `CMP_MASK` is 0 do not affect either chip select. The default mask 12'hFF8 gives an 8-address window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Active-high reset; its release latches the straps |
| mclk_pin_i | input | 1 | Level read on the master-clock pin (strap) |
| mclk_src | input | 1 | Clock to forward onto the master-clock pin |
| mclk_out | output | 1 | Master-clock pin output value |
| mclk_oe | output | 1 | Master-clock pin output enable |
| alt_strap_i | input | 1 | Alternate-select strap level |
| hi_pin_i | input | 4 | Levels read on the upper-address pins |
| hi_pin_o | output | 4 | Upper-address pin output values |
| hi_pin_oe | output | 4 | Upper-address pin output enables |
| addr_hi | output | 4 | Address bits 12 to 15 taken from the pins, 0 when taken over |
| bus_addr | input | 12 | Bus address for the decoders |
| cd_base | input | 12 | Primary base address register |
| alt_base | input | 12 | Alternate base address register |
| gpo_bit | input | 1 | General-purpose output control bit |
| vol_en | input | 1 | Volume-control enable |
| clk_dis | input | 1 | Master-clock disable |
| xpin_i | input | 1 | Level read on the three-way shared pin |
| xpin_o | output | 1 | Three-way shared pin output value |
| xpin_oe | output | 1 | Three-way shared pin output enable |
| vol_btn | output | 1 | Sampled volume button level |

## Verification
Two of the results are registered and take one rising edge. The straps take effect at the first edge after `rst` falls, and `clk_dis` acts at the edge after it changes. The bench drives those inputs at a falling edge and samples shortly after the next falling edge. It also samples once before the edge, so that it can confirm nothing changed early. Chip selects, the shared pin roles and `vol_btn` are combinational in the current state, so they are due in the same cycle. The bench changes the inputs at a falling edge and samples one nanosecond later.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } pm_state_e;
endpackage

// File: rtl/pm_addr_cmp.sv
module pm_addr_cmp #(
    parameter int                ADDR_W = 12,
    parameter logic [ADDR_W-1:0] MASK   = '1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output logic              hit
);
    always_comb hit = ((addr ^ base) & MASK) == '0;
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
    import pm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mclk_strap,
    input  logic      alt_strap,
    input  logic      clk_dis,
    output pm_state_e st,
    output logic      cd_en,
    output logic      alt_en
);
    pm_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_HOLD;
        else     st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_HOLD: nxt = ST_RUN;
            ST_RUN:  if (clk_dis)  nxt = ST_STOP;
            ST_STOP: if (!clk_dis) nxt = ST_RUN;
            default: nxt = ST_HOLD;
        endcase
    end

    // Straps load only on the HOLD -> RUN transition.
    always_ff @(posedge clk) begin
        if (!rst && st == ST_HOLD) begin
            cd_en  <= ~mclk_strap;
            alt_en <= ~alt_strap;
        end
    end
endmodule

// File: rtl/pinmux_strap_top.sv
module pinmux_strap_top
    import pm_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                HI_W     = 4,
    parameter logic [ADDR_W-1:0] CMP_MASK = 12'hFF8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mclk_pin_i,
    input  logic              mclk_src,
    output logic              mclk_out,
    output logic              mclk_oe,
    input  logic              alt_strap_i,
    input  logic [HI_W-1:0]   hi_pin_i,
    output logic [HI_W-1:0]   hi_pin_o,
    output logic [HI_W-1:0]   hi_pin_oe,
    output logic [HI_W-1:0]   addr_hi,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] cd_base,
    input  logic [ADDR_W-1:0] alt_base,
    input  logic              gpo_bit,
    input  logic              vol_en,
    input  logic              clk_dis,
    input  logic              xpin_i,
    output logic              xpin_o,
    output logic              xpin_oe,
    output logic              vol_btn
);
    localparam int REST_W = HI_W - 1;

    pm_state_e st;
    logic      cd_en;
    logic      alt_en;
    logic      pri_hit;
    logic      alt_hit;

    pm_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mclk_strap (mclk_pin_i),
        .alt_strap  (alt_strap_i),
        .clk_dis    (clk_dis),
        .st         (st),
        .cd_en      (cd_en),
        .alt_en     (alt_en)
    );

    pm_addr_cmp #(.ADDR_W(ADDR_W), .MASK(CMP_MASK)) u_pri_cmp (
        .addr (bus_addr),
        .base (cd_base),
        .hit  (pri_hit)
    );

    pm_addr_cmp #(.ADDR_W(ADDR_W), .MASK(CMP_MASK)) u_alt_cmp (
        .addr (bus_addr),
        .base (alt_base),
        .hit  (alt_hit)
    );

    always_comb begin
        mclk_oe   = 1'b0;
        mclk_out  = 1'b0;
        hi_pin_oe = '0;
        hi_pin_o  = '1;
        addr_hi   = hi_pin_i;
        xpin_o    = 1'b1;
        xpin_oe   = 1'b1;
        vol_btn   = 1'b0;
        unique case (st)
            ST_HOLD: begin
                // Clock pin released for strap reading, selects idle.
                xpin_o  = 1'b1;
                xpin_oe = 1'b1;
            end
            ST_RUN, ST_STOP: begin
                mclk_oe  = 1'b1;
                mclk_out = (st == ST_RUN) && mclk_src;
                if (cd_en) begin
                    hi_pin_oe = '1;
                    hi_pin_o  = {{REST_W{1'b1}}, ~pri_hit};
                    addr_hi   = '0;
                end
                // Precedence: volume enable, then alternate select, then GPO.
                if (vol_en) begin
                    xpin_oe = 1'b0;
                    vol_btn = xpin_i;
                end else if (alt_en) begin
                    xpin_o = ~alt_hit;
                end else begin
                    xpin_o = gpo_bit;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pm_chk.sv
module pm_chk
    import pm_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input pm_state_e st,
    input logic      cd_en,
    input logic      alt_en,
    input logic      vol_en,
    input logic      clk_dis,
    input logic      xpin_i,
    input logic      xpin_oe,
    input logic      vol_btn,
    input logic [3:0] hi_pin_oe,
    input logic [3:0] hi_pin_o,
    input logic      mclk_oe,
    input logic      mclk_out
);
    // R1
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD) |-> (!mclk_oe && hi_pin_o[0] && hi_pin_oe == 4'h0));

    // R2
    strap_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_HOLD && $past(st) != ST_HOLD) |-> ($stable(cd_en) && $stable(alt_en)));

    // R3
    pins_input_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_HOLD && !cd_en) |-> (hi_pin_oe == 4'h0));

    // R7
    vol_over_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_HOLD && vol_en) |-> (!xpin_oe && vol_btn == xpin_i));

    // R9
    clk_stop_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(clk_dis) && $past(st) != ST_HOLD && st != ST_HOLD) |-> !mclk_out);
endmodule

bind pinmux_strap_top pm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .cd_en     (cd_en),
    .alt_en    (alt_en),
    .vol_en    (vol_en),
    .clk_dis   (clk_dis),
    .xpin_i    (xpin_i),
    .xpin_oe   (xpin_oe),
    .vol_btn   (vol_btn),
    .hi_pin_oe (hi_pin_oe),
    .hi_pin_o  (hi_pin_o),
    .mclk_oe   (mclk_oe),
    .mclk_out  (mclk_out)
);

// File: tb/sim_pinmux_strap_top.sv
`timescale 1ns/1ps
module sim_pinmux_strap_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mclk_pin_i = 1'b1, mclk_src = 1'b0, alt_strap_i = 1'b1;
    logic [3:0]  hi_pin_i = 4'h0;
    logic [11:0] bus_addr = '0, cd_base = 12'h1F0, alt_base = 12'h170;
    logic        gpo_bit = 1'b0, vol_en = 1'b0, clk_dis = 1'b0, xpin_i = 1'b0;
    logic        mclk_out, mclk_oe, xpin_o, xpin_oe, vol_btn;
    logic [3:0]  hi_pin_o, hi_pin_oe, addr_hi;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    pinmux_strap_top u0 (
        .clk(clk), .rst(rst), .mclk_pin_i(mclk_pin_i), .mclk_src(mclk_src),
        .mclk_out(mclk_out), .mclk_oe(mclk_oe), .alt_strap_i(alt_strap_i),
        .hi_pin_i(hi_pin_i), .hi_pin_o(hi_pin_o), .hi_pin_oe(hi_pin_oe),
        .addr_hi(addr_hi), .bus_addr(bus_addr), .cd_base(cd_base),
        .alt_base(alt_base), .gpo_bit(gpo_bit), .vol_en(vol_en),
        .clk_dis(clk_dis), .xpin_i(xpin_i), .xpin_o(xpin_o),
        .xpin_oe(xpin_oe), .vol_btn(vol_btn)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle; @(negedge clk); #1; endtask

    // Reset with the given straps, check idle outputs, release, flip the straps.
    task automatic t_reset(logic s_mclk, logic s_alt);
        @(negedge clk);
        rst = 1'b1; mclk_pin_i = s_mclk; alt_strap_i = s_alt;
        repeat (2) @(posedge clk);
        settle();
        chk("R1 mclk_oe", mclk_oe, 0);
        chk("R1 hi_pin_oe", hi_pin_oe, 0);
        chk("R1 hi_pin_o", hi_pin_o, 4'hF);
        chk("R1 xpin", {xpin_oe, xpin_o}, 2'b11);
        chk("R1 vol_btn", vol_btn, 0);
        rst = 1'b0;
        settle();
        mclk_pin_i = ~s_mclk; alt_strap_i = ~s_alt;  // R2: late changes ignored
        repeat (2) settle();
    endtask

    task automatic t_default;
        t_reset(1'b1, 1'b1);
        hi_pin_i = 4'hA; #1;
        chk("R3 inputs oe", hi_pin_oe, 0);
        chk("R3 addr_hi", addr_hi, 4'hA);
        chk("R2 strap kept", hi_pin_oe, 0);
        gpo_bit = 1'b1; #1;
        chk("R5 gpo 1", {xpin_oe, xpin_o}, 2'b11);
        gpo_bit = 1'b0; #1;
        chk("R5 gpo 0", {xpin_oe, xpin_o}, 2'b10);
        chk("R7 vol_btn idle", vol_btn, 0);
        mclk_src = 1'b1; #1;
        chk("R8 mclk 1", {mclk_oe, mclk_out}, 2'b11);
        mclk_src = 1'b0; #1;
        chk("R8 mclk 0", {mclk_oe, mclk_out}, 2'b10);
    endtask

    task automatic t_disk;
        t_reset(1'b0, 1'b1);
        hi_pin_i = 4'h5; #1;
        chk("R3 outputs oe", hi_pin_oe, 4'hF);
        chk("R3 addr_hi zero", addr_hi, 0);
        bus_addr = 12'h1F3; #1;
        chk("R4 hit", hi_pin_o, 4'hE);
        bus_addr = 12'h1F7; #1;
        chk("R10 masked bits", hi_pin_o, 4'hE);
        bus_addr = 12'h1F8; #1;
        chk("R4 miss", hi_pin_o, 4'hF);
        chk("R5 gpo in disk mode", xpin_o, gpo_bit);
    endtask

    task automatic t_alt;
        t_reset(1'b1, 1'b0);
        gpo_bit = 1'b1;
        bus_addr = 12'h175; #1;
        chk("R6 alt hit", {xpin_oe, xpin_o}, 2'b10);
        bus_addr = 12'h200; gpo_bit = 1'b0; #1;
        chk("R6 alt miss gpo ignored", xpin_o, 1);
        chk("R2 disk strap kept off", hi_pin_oe, 0);
    endtask

    task automatic t_vol;
        vol_en = 1'b1; xpin_i = 1'b1; #1;
        chk("R7 vol input 1", {xpin_oe, vol_btn}, 2'b01);
        xpin_i = 1'b0; #1;
        chk("R7 vol input 0", {xpin_oe, vol_btn}, 2'b00);
        vol_en = 1'b0; bus_addr = 12'h170; #1;
        chk("R7 back to alt", {xpin_oe, xpin_o, vol_btn}, 3'b100);
    endtask

    task automatic t_clk;
        mclk_src = 1'b1;
        settle();
        clk_dis = 1'b1; #1;
        chk("R9 not before edge", mclk_out, 1);
        settle();
        chk("R9 stopped", {mclk_oe, mclk_out}, 2'b10);
        clk_dis = 1'b0; #1;
        chk("R9 still stopped before edge", mclk_out, 0);
        settle();
        chk("R9 resumed", mclk_out, 1);
    endtask

    initial begin
        t_default();
        t_disk();
        t_alt();
        t_vol();
        t_clk();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule